// File: doc/BRIEF.md
# Data Bus Line Test Sequencer

This block checks the data lines of a 64-bit memory port for shorts and opens. After a start request it runs through twelve alternating-bit words on its own. Six of these have runs of ones and zeros whose length doubles from 1 to 32. The other six are their complements. Every pair of adjacent data lines, however the lines are routed, is therefore driven to opposite levels at some point in the run.

Each test word is handled in three steps:

1. The word is written to a target location.
2. A fixed decoy word is written to the next location. This moves the bus away from the test word, so a line left floating cannot keep the value that was just written.
3. The target is read back once, and that single captured value is compared.

A mismatch does not stop the run. It is reported on an error strobe together with the failing pattern number, the word that was expected and the word that was read. A sticky fail flag collects all mismatches of the run.

A controller drives the block in three steps. It places a word address on `base_addr_i`, pulses `start_i`, and then waits for `done_o`. The memory side is a request/ready port. A read result comes back later on a valid strobe.

Top module: `dbt_sequencer`

## Requirements
- R1: While reset is held and after reset, `busy_o`, `done_o`, `fail_o`, `err_o` and `mem_req_o` are all 0.
- R2: The words are applied by pattern index 0..11 in this order: AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, then the bitwise complements of these six in reverse order (00000000FFFFFFFF up to 5555555555555555). All values are hexadecimal.
- R3: Each pattern uses exactly three memory transactions, in this order:
  - a write of the pattern to the base address;
  - a write of 0123456789ABCDEF to base address + 1;
  - a read of the base address.
- R4: Once `mem_req_o` is raised, it stays high until `mem_ready_i` is seen. Until then `mem_addr_o`, `mem_we_o` and `mem_wdata_o` do not change.
- R5: Read data is taken only on `mem_rvalid_i` while a read is outstanding, and the read latency may be any value of one cycle or more. A valid strobe that arrives while no read is outstanding has no effect. The target is read exactly once per pattern.
- R6: The cycle after a mismatching read result, `err_o` is high for one cycle. During that cycle `err_idx_o` holds the pattern index, `err_exp_o` the pattern and `err_obs_o` the value that was captured.
- R7: All twelve patterns are applied whether or not mismatches occur. `fail_o` is set by any mismatch and stays set after the run. It is cleared only when the next start is accepted.
- R8: `done_o` is high for exactly one cycle, the cycle after the twelfth read result. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle, and low after that.
- R9: A `start_i` that arrives while `busy_o` is high is ignored: the base address and the run in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start_i | input | 1 | Start request, accepted only when idle |
| base_addr_i | input | ADDR_W | Word address of the target location |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Sticky mismatch flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Request accepted in this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| err_o | output | 1 | Mismatch strobe |
| err_idx_o | output | IDX_W | Pattern index of the mismatch |
| err_exp_o | output | DATA_W | Expected word |
| err_obs_o | output | DATA_W | Captured word |

## Verification
The hardest case to reach is a data line that reads back whatever the bus last carried. The decoy write exists to expose exactly this fault. The bench memory model can make chosen bit lanes return the last written bus value, so the error report must show decoy bytes in those lanes. A second hard case is a stray read-valid strobe during the write phase. The model fires one with garbage data right after the first write is accepted, and no error may follow. Ready stalls and read latencies from 1 to 7 cycles are mixed across runs. A second start is pulsed in the middle of one run to show that it is ignored.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WR_PAT   = 3'd1,
      ST_WR_DECOY = 3'd2,
      ST_RD_REQ   = 3'd3,
      ST_RD_WAIT  = 3'd4,
      ST_FIN      = 3'd5
   } dbt_state_e;

endpackage

// File: rtl/dbt_pattern_gen.sv
module dbt_pattern_gen #(
   parameter int DATA_W = 64,
   localparam int LOG_W = $clog2(DATA_W),
   localparam int NUM_PAT = 2 * LOG_W,
   localparam int IDX_W = $clog2(NUM_PAT)
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DATA_W-1:0] pat_o
);

   logic [DATA_W-1:0] walk [LOG_W];
   logic [DATA_W-1:0] tbl  [NUM_PAT];

   // Word k has bit j set when bit k of j is set; the complements follow in reverse order.
   for (genvar k = 0; k < LOG_W; k++) begin : g_pat
      for (genvar j = 0; j < DATA_W; j++) begin : g_bit
         assign walk[k][j] = ((j >> k) & 1) != 0;
      end
      assign tbl[k]             = walk[k];
      assign tbl[NUM_PAT-1-k]   = ~walk[k];
   end

   always_comb begin
      pat_o = '0;
      for (int i = 0; i < NUM_PAT; i++) begin
         if (idx_i == IDX_W'(i)) pat_o = tbl[i];
      end
   end

endmodule

// File: rtl/dbt_compare.sv
module dbt_compare #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              cap_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] exp_i,
   input  logic [DATA_W-1:0] obs_i,
   output logic              err_o,
   output logic [IDX_W-1:0]  err_idx_o,
   output logic [DATA_W-1:0] err_exp_o,
   output logic [DATA_W-1:0] err_obs_o,
   output logic              fail_o
);

   logic miss;
   assign miss = cap_i && (obs_i != exp_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o     <= 1'b0;
         err_idx_o <= '0;
         err_exp_o <= '0;
         err_obs_o <= '0;
         fail_o    <= 1'b0;
      end else begin
         err_o <= miss;
         if (miss) begin
            err_idx_o <= idx_i;
            err_exp_o <= exp_i;
            err_obs_o <= obs_i;
         end
         if (clear_i)   fail_o <= 1'b0;
         else if (miss) fail_o <= 1'b1;
      end
   end

endmodule

// File: rtl/dbt_sequencer.sv
module dbt_sequencer #(
   parameter int          DATA_W     = 64,
   parameter int          ADDR_W     = 32,
   parameter logic [63:0] DECOY_WORD = 64'h0123_4567_89AB_CDEF,
   localparam int LOG_W   = $clog2(DATA_W),
   localparam int NUM_PAT = 2 * LOG_W,
   localparam int IDX_W   = $clog2(NUM_PAT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ready_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              err_o,
   output logic [IDX_W-1:0]  err_idx_o,
   output logic [DATA_W-1:0] err_exp_o,
   output logic [DATA_W-1:0] err_obs_o
);
   import dbt_pkg::*;

   localparam logic [DATA_W-1:0] DECOY    = DECOY_WORD[DATA_W-1:0];
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PAT - 1);

   if (DATA_W < 8 || DATA_W > 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("dbt_sequencer: DATA_W must be a power of two from 8 to 64");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dbt_sequencer: ADDR_W must be at least 2");
   end

   dbt_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic [DATA_W-1:0] pat;
   logic              start_acc;
   logic              capture;

   assign start_acc = (state_q == ST_IDLE) && start_i;
   assign capture   = (state_q == ST_RD_WAIT) && mem_rvalid_i;

   dbt_pattern_gen #(.DATA_W(DATA_W)) u_pat (
      .idx_i (idx_q),
      .pat_o (pat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               base_q  <= base_addr_i;
               idx_q   <= '0;
               state_q <= ST_WR_PAT;
            end
            ST_WR_PAT:   if (mem_ready_i) state_q <= ST_WR_DECOY;
            ST_WR_DECOY: if (mem_ready_i) state_q <= ST_RD_REQ;
            ST_RD_REQ:   if (mem_ready_i) state_q <= ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid_i) begin
               if (idx_q == LAST_IDX) state_q <= ST_FIN;
               else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_WR_PAT;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = (state_q == ST_WR_PAT) || (state_q == ST_WR_DECOY) || (state_q == ST_RD_REQ);
      mem_we_o    = (state_q == ST_WR_PAT) || (state_q == ST_WR_DECOY);
      mem_addr_o  = (state_q == ST_WR_DECOY) ? base_q + 1'b1 : base_q;
      mem_wdata_o = (state_q == ST_WR_DECOY) ? DECOY : pat;
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_FIN);

   dbt_compare #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_acc),
      .cap_i     (capture),
      .idx_i     (idx_q),
      .exp_i     (pat),
      .obs_i     (mem_rdata_i),
      .err_o     (err_o),
      .err_idx_o (err_idx_o),
      .err_exp_o (err_exp_o),
      .err_obs_o (err_obs_o),
      .fail_o    (fail_o)
   );

endmodule

// File: rtl/dbt_sequencer_chk.sv
module dbt_sequencer_chk #(
   parameter int          DATA_W     = 64,
   parameter int          ADDR_W     = 32,
   parameter logic [63:0] DECOY_WORD = 64'h0123_4567_89AB_CDEF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              fail_o,
   input logic              err_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic              mem_ready_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic [ADDR_W-1:0] base_q
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o && !done_o);

   assert_decoy_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o && (mem_addr_o != base_q) |-> mem_wdata_o == DECOY_WORD[DATA_W-1:0]);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

   assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   assert_err_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> busy_o);

   assert_fail_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_o) |-> err_o);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   assert_start_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_base_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(base_q));

endmodule

bind dbt_sequencer dbt_sequencer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DECOY_WORD(DECOY_WORD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .fail_o      (fail_o),
   .err_o       (err_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_ready_i (mem_ready_i),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .base_q      (base_q)
);

// File: tb/tb_dbt_sequencer.sv
module tb_dbt_sequencer;

   localparam int DW = 64;
   localparam int AW = 32;
   localparam int NP = 12;
   localparam logic [63:0] DECOY = 64'h0123456789ABCDEF;
   localparam logic [63:0] PATS [NP] = '{
      64'hAAAAAAAAAAAAAAAA, 64'hCCCCCCCCCCCCCCCC, 64'hF0F0F0F0F0F0F0F0,
      64'hFF00FF00FF00FF00, 64'hFFFF0000FFFF0000, 64'hFFFFFFFF00000000,
      64'h00000000FFFFFFFF, 64'h0000FFFF0000FFFF, 64'h00FF00FF00FF00FF,
      64'h0F0F0F0F0F0F0F0F, 64'h3333333333333333, 64'h5555555555555555};

   typedef struct packed {
      logic [31:0] base;
      logic [63:0] s1;
      logic [63:0] s0;
      logic [63:0] fl;
      int          lat;
      int          stall;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 64'h0, 64'h0, 64'h0, 1, 0},
      '{32'h0000_0005, 64'h0000_0000_0000_8000, 64'h0, 64'h0, 3, 1},
      '{32'hFFFF_FFFE, 64'h0, 64'h0, 64'h0, 2, 2},
      '{32'h0000_0009, 64'h0, 64'h00FF_0000_0000_0000, 64'h0, 2, 0},
      '{32'h0000_0002, 64'h0, 64'h0, 64'h0000_FF00_0000_0000, 1, 0},
      '{32'h0000_000B, 64'h1, 64'h2, 64'h0, 4, 3},
      '{32'h0000_1234, 64'h0, 64'h0, 64'h0, 7, 1}};

   logic          clk, rst_n, start_i;
   logic [AW-1:0] base_addr_i;
   logic          busy_o, done_o, fail_o;
   logic          mem_req_o, mem_we_o, mem_ready_i, mem_rvalid_i;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o, mem_rdata_i;
   logic          err_o;
   logic [3:0]    err_idx_o;
   logic [DW-1:0] err_exp_o, err_obs_o;

   dbt_sequencer dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
      .err_o(err_o), .err_idx_o(err_idx_o), .err_exp_o(err_exp_o), .err_obs_o(err_obs_o));

   int n_chk = 0;
   int n_fail = 0;

   initial begin
      clk = 1'b0;
      forever #10 clk = ~clk;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // responder state
   vec_t        cur;
   bit          stray_en = 0, stray_armed = 0;
   int          hs = 0, rd_seen = 0, err_seen = 0, rd_pend = 0, stall_left = 0;
   logic [63:0] mem [16];
   logic [63:0] last_bus = '0;
   bit          prev_stall = 0;
   logic [31:0] prev_addr = '0;

   function automatic logic [63:0] obs_of(input logic [63:0] p, input vec_t v);
      return (((p & ~v.fl) | (DECOY & v.fl)) & ~v.s0) | v.s1;
   endfunction

   initial begin
      mem_ready_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0;
      cur = VECS[0];
      foreach (mem[i]) mem[i] = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            mem_ready_i = 0; mem_rvalid_i = 0;
            continue;
         end
         mem_rvalid_i = 0;
         if (rd_pend > 0) begin
            rd_pend--;
            if (rd_pend == 0) begin
               mem_rvalid_i = 1;
               mem_rdata_i  = (((mem[cur.base[3:0]] & ~cur.fl) | (last_bus & cur.fl)) & ~cur.s0) | cur.s1;
            end
         end else if (stray_armed) begin
            mem_rvalid_i = 1;        // stray strobe while writes are in progress (R5)
            mem_rdata_i  = 64'hDEAD_BEEF_DEAD_BEEF;
            stray_armed  = 0;
         end
         if (err_o) begin
            chk(err_idx_o == 4'(rd_seen - 1), "R6 err index", 64'(err_idx_o), 64'(rd_seen - 1));
            chk(err_exp_o == PATS[rd_seen-1], "R6 err expected word", err_exp_o, PATS[rd_seen-1]);
            chk(err_obs_o == obs_of(PATS[rd_seen-1], cur), "R6 err observed word", err_obs_o, obs_of(PATS[rd_seen-1], cur));
            err_seen++;
         end
         if (prev_stall) chk(mem_req_o && mem_addr_o == prev_addr, "R4 request held", 64'(mem_addr_o), 64'(prev_addr));
         prev_stall  = 0;
         mem_ready_i = 0;
         if (mem_req_o) begin
            if (stall_left > 0) begin
               stall_left--;
               prev_stall = 1;
               prev_addr  = mem_addr_o;
            end else if (hs >= 3 * NP) begin
               chk(0, "R3 extra transaction", 64'(hs), 64'(3 * NP));
               mem_ready_i = 1;
            end else begin
               mem_ready_i = 1;
               stall_left  = cur.stall;
               case (hs % 3)
                  0: begin
                     chk(mem_we_o && mem_addr_o == cur.base, "R3 pattern write addr", 64'(mem_addr_o), 64'(cur.base));
                     chk(mem_wdata_o == PATS[hs/3], "R2 pattern value", mem_wdata_o, PATS[hs/3]);
                  end
                  1: begin
                     chk(mem_we_o && mem_addr_o == cur.base + 1, "R3 decoy addr", 64'(mem_addr_o), 64'(cur.base + 1));
                     chk(mem_wdata_o == DECOY, "R3 decoy value", mem_wdata_o, DECOY);
                  end
                  default: begin
                     chk(!mem_we_o && mem_addr_o == cur.base, "R5 single read of target", 64'(mem_addr_o), 64'(cur.base));
                     rd_pend = cur.lat;
                     rd_seen++;
                  end
               endcase
               if (mem_we_o) begin
                  mem[mem_addr_o[3:0]] = mem_wdata_o;
                  last_bus = mem_wdata_o;
                  if (hs == 0 && stray_en) stray_armed = 1;
               end
               hs++;
            end
         end
      end
   end

   task automatic run_vec(input vec_t v, input bit stray, input bit restart);
      int expcnt = 0;
      bit got_done = 0;
      for (int i = 0; i < NP; i++) if (obs_of(PATS[i], v) != PATS[i]) expcnt++;
      cur = v; stray_en = stray; hs = 0; rd_seen = 0; err_seen = 0;
      rd_pend = 0; stall_left = v.stall;
      @(negedge clk);
      start_i = 1; base_addr_i = v.base;
      @(negedge clk);
      start_i = 0;
      chk(busy_o, "R8 busy after start", 64'(busy_o), 1);
      if (restart) begin
         repeat (4) @(negedge clk);
         start_i = 1; base_addr_i = v.base + 32'h40;   // R9: must be ignored
         @(negedge clk);
         start_i = 0;
      end
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (done_o) begin got_done = 1; break; end
         if (!busy_o) break;
      end
      chk(got_done, "R8 done pulse seen", 64'(got_done), 1);
      chk(rd_seen == NP, "R7 all patterns read", 64'(rd_seen), 64'(NP));
      chk(busy_o, "R8 busy during done", 64'(busy_o), 1);
      @(negedge clk);
      chk(!done_o, "R8 done one cycle", 64'(done_o), 0);
      chk(!busy_o, "R8 idle after done", 64'(busy_o), 0);
      chk(err_seen == expcnt, "R7 mismatch count", 64'(err_seen), 64'(expcnt));
      repeat (3) @(negedge clk);
      chk(fail_o == (expcnt > 0), "R7 sticky fail", 64'(fail_o), 64'(expcnt > 0));
      chk(hs == 3 * NP, "R3 transaction count", 64'(hs), 64'(3 * NP));
   endtask

   initial begin
      rst_n = 0; start_i = 0; base_addr_i = '0;
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !fail_o && !err_o && !mem_req_o, "R1 reset outputs",
          {59'b0, busy_o, done_o, fail_o, err_o, mem_req_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy_o && !mem_req_o, "R1 idle after reset", {62'b0, busy_o, mem_req_o}, 0);
      for (int v = 0; v < NV; v++) run_vec(VECS[v], 0, 0);
      // directed: stray strobe during writes must not be taken (R5)
      run_vec(VECS[0], 1, 0);
      // directed: restart while busy on a failing setup (R9), then passing run clears fail (R7)
      run_vec(VECS[1], 0, 1);
      run_vec(VECS[6], 1, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule